// File: doc/BRIEF.md
# Video RAM Fill Engine

This block carries out the fill kind of DMA into a 64 KB video memory that is addressed by byte. Software programs a small set of 8-bit registers: an auto-increment step, a 16-bit length, a 16-bit source pointer and a source-high byte whose top bit selects fill mode. It then issues a DMA write command with a start address. The engine arms and waits for one data-port word. That word is written to memory like any ordinary data write. After that, the engine writes the word's high byte again and again, one byte per clock, stepping the address by the auto-increment until the length runs out.

The memory side is a word-wide write port with two byte strobes, so a full word or a single byte leaves in one cycle. While the engine is idle, data-port words that do not trigger a fill go out as ordinary word writes at the current address, and the address then advances. A busy output covers the span from arming to the last fill byte. The length and source registers are visible on output ports, so the way they count is observable from outside.

Top module: `vfill_engine`

## Requirements
- R1: A register write sets register `reg_idx` to `reg_val` when the engine is not busy. Index 15 is the auto-increment, 19/20 are the length low/high bytes, 21/22 are the source low/middle bytes and 23 is the source-high byte. A command with `cmd_dma`=1 while bit 7 of register 23 is 1 arms the fill, and `busy` is 1 in the next cycle.
- R2: A command with `cmd_dma`=0, or with bit 7 of register 23 at 0, only loads the address and does not arm. The next data word becomes one ordinary word write and `busy` stays 0.
- R3: The memory port takes the word address `ram_addr` = byte address >> 1. `ram_be[1]` enables the even byte on `ram_wdata[15:8]` and `ram_be[0]` enables the odd byte on `ram_wdata[7:0]`. A word written at an even address places its high byte at the address and its low byte at address+1. At an odd address the same pair receives the two bytes swapped.
- R4: A data word accepted in a given cycle appears on the memory port one cycle later. After it, the current address advances by register 15, and this includes the word that triggers a fill.
- R5: Each fill step writes one byte per cycle, the trigger word's high byte, to the current address XOR 1. The address then advances by register 15, modulo 65536. The fill steps follow the trigger write back to back.
- R6: Each fill step decrements the length {reg 20, reg 19}, and the fill ends with the step that brings it to 0. A programmed length of 0 gives 65536 steps.
- R7: Each fill step increments the source pointer {reg 22, reg 21}, wrapping at 16 bits, and leaves register 23 unchanged. Rewriting only the length and register 23 afterwards keeps the advanced pointer.
- R8: `busy` is 0 after reset and stays 1 from the cycle after arming through the cycle in which the last fill byte is presented. It is 0 in the cycle that follows.
- R9: While `busy` is 1, register writes, commands and data words are ignored, except the single word that triggers an armed fill.
- R10: With auto-increment 3 and length 3, word 0x1122 fills bytes 11 22 11 00 00 00 00 11 11 from an even start of 0x100. From an odd start of 0x101 the bytes from 0x100 are 22 11 00 00 00 11 11 00 00 00 00 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index |
| reg_val | input | 8 | Register write value |
| cmd_wr | input | 1 | Write-command strobe (loads the address) |
| cmd_dma | input | 1 | Command requests DMA |
| cmd_addr | input | 16 | Command byte address |
| data_wr | input | 1 | Data-port word strobe |
| data_val | input | 16 | Data-port word |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | 15 | Memory word address |
| ram_be | output | 2 | Byte strobes: bit 1 even byte, bit 0 odd byte |
| ram_wdata | output | 16 | Memory write data |
| busy | output | 1 | Fill armed or running |
| len_o | output | 16 | Current length register pair |
| src_o | output | 24 | Source registers {23, 22, 21} |

## Verification
Two functions can meet in the same cycle. One is a fill step, which decrements the length and advances the source and the address. The other is a register write, command or data word arriving from outside. The bench provokes this by pulsing a length write, an auto-increment write, a command and a data word both while the engine is armed and in the middle of an eight-step fill. It judges the result by the exact sequence of memory writes on the scoreboard, by the length reading 7 one cycle into the fill, and by the length and source values read at the ports once `busy` drops.

// File: rtl/vfill_pkg.sv
package vfill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FILL  = 2'd2
    } fill_state_e;

    localparam int IDX_W = 5;

    // register indices decoded by the register bank
    localparam logic [IDX_W-1:0] RI_INC     = 5'd15;
    localparam logic [IDX_W-1:0] RI_LEN_LO  = 5'd19;
    localparam logic [IDX_W-1:0] RI_LEN_HI  = 5'd20;
    localparam logic [IDX_W-1:0] RI_SRC_LO  = 5'd21;
    localparam logic [IDX_W-1:0] RI_SRC_MID = 5'd22;
    localparam logic [IDX_W-1:0] RI_SRC_HI  = 5'd23;

endpackage

// File: rtl/vfill_lane.sv
// Byte placement onto a two-lane word port.
module vfill_lane #(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [2*REG_W-1:0] word_i,
    input  logic               fill_i,
    output logic [ADDR_W-2:0]  waddr_o,
    output logic [1:0]         be_o,
    output logic [2*REG_W-1:0] wdata_o
);
    localparam int WORD_W = 2 * REG_W;

    logic [REG_W-1:0] hi_b;
    logic [REG_W-1:0] lo_b;
    logic             tgt_odd;

    always_comb begin
        hi_b    = word_i[WORD_W-1:REG_W];
        lo_b    = word_i[REG_W-1:0];
        waddr_o = addr_i[ADDR_W-1:1];
        // fill target is address XOR 1: odd when the address is even
        tgt_odd = ~addr_i[0];
        if (fill_i) begin
            be_o    = tgt_odd ? 2'b01 : 2'b10;
            wdata_o = {hi_b, hi_b};
        end else begin
            be_o    = 2'b11;
            wdata_o = addr_i[0] ? {lo_b, hi_b} : {hi_b, lo_b};
        end
    end

endmodule

// File: rtl/vfill_regs.sv
// Auto-increment, length and source registers with fill-step update.
module vfill_regs
    import vfill_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]   wr_val,
    input  logic               step,
    output logic [REG_W-1:0]   inc_o,
    output logic [2*REG_W-1:0] len_o,
    output logic [3*REG_W-1:0] src_o,
    output logic               fill_sel_o
);
    localparam int PAIR_W = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0]  inc;
        logic [PAIR_W-1:0] len;
        logic [PAIR_W-1:0] src;
        logic [REG_W-1:0]  src_hi;
    } regs_s;

    regs_s r_d;
    regs_s r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_idx)
                RI_INC:     r_d.inc               = wr_val;
                RI_LEN_LO:  r_d.len[REG_W-1:0]    = wr_val;
                RI_LEN_HI:  r_d.len[PAIR_W-1:REG_W] = wr_val;
                RI_SRC_LO:  r_d.src[REG_W-1:0]    = wr_val;
                RI_SRC_MID: r_d.src[PAIR_W-1:REG_W] = wr_val;
                RI_SRC_HI:  r_d.src_hi            = wr_val;
                default:    ;
            endcase
        end else if (step) begin
            r_d.len = r_q.len - PAIR_W'(1);
            r_d.src = r_q.src + PAIR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign inc_o      = r_q.inc;
    assign len_o      = r_q.len;
    assign src_o      = {r_q.src_hi, r_q.src};
    assign fill_sel_o = r_q.src_hi[REG_W-1];

endmodule

// File: rtl/vfill_ctrl.sv
// Arming, trigger word, fill sequencing and registered memory port.
module vfill_ctrl
    import vfill_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_dma,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               data_wr,
    input  logic [2*REG_W-1:0] data_val,
    input  logic               fill_sel,
    input  logic [2*REG_W-1:0] len,
    input  logic [REG_W-1:0]   inc,
    output logic               fill_step,
    output logic               busy,
    output logic               ram_we,
    output logic [ADDR_W-2:0]  ram_addr,
    output logic [1:0]         ram_be,
    output logic [2*REG_W-1:0] ram_wdata
);
    localparam int WORD_W = 2 * REG_W;

    typedef struct packed {
        fill_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  hold;
        logic              busy;
        logic              we;
        logic [ADDR_W-2:0] waddr;
        logic [1:0]        be;
        logic [WORD_W-1:0] wdata;
    } ctrl_s;

    ctrl_s c_d;
    ctrl_s c_q;

    logic              lane_fill;
    logic [WORD_W-1:0] lane_word;
    logic [ADDR_W-2:0] lane_waddr;
    logic [1:0]        lane_be;
    logic [WORD_W-1:0] lane_wdata;
    logic [ADDR_W-1:0] addr_next;
    logic              last_step;

    assign lane_fill = (c_q.st == ST_FILL);
    assign lane_word = lane_fill ? {c_q.hold, REG_W'(0)} : data_val;
    assign addr_next = c_q.addr + ADDR_W'(inc);
    assign last_step = (len == WORD_W'(1));

    vfill_lane #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_lane (
        .addr_i  (c_q.addr),
        .word_i  (lane_word),
        .fill_i  (lane_fill),
        .waddr_o (lane_waddr),
        .be_o    (lane_be),
        .wdata_o (lane_wdata)
    );

    always_comb begin
        c_d       = c_q;
        c_d.we    = 1'b0;
        fill_step = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (!c_q.busy) begin
                    if (cmd_wr) begin
                        c_d.addr = cmd_addr;
                        if (cmd_dma && fill_sel) begin
                            c_d.st = ST_ARMED;
                        end
                    end else if (data_wr) begin
                        c_d.we   = 1'b1;
                        c_d.addr = addr_next;
                    end
                end
            end
            ST_ARMED: begin
                if (data_wr) begin
                    c_d.we   = 1'b1;
                    c_d.addr = addr_next;
                    c_d.hold = data_val[WORD_W-1:REG_W];
                    c_d.st   = ST_FILL;
                end
            end
            ST_FILL: begin
                fill_step = 1'b1;
                c_d.we    = 1'b1;
                c_d.addr  = addr_next;
                if (last_step) begin
                    c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        c_d.busy  = (c_d.st != ST_IDLE) || (c_q.st == ST_FILL);
        c_d.waddr = lane_waddr;
        c_d.be    = lane_be;
        c_d.wdata = lane_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = c_q.busy;
    assign ram_we    = c_q.we;
    assign ram_addr  = c_q.waddr;
    assign ram_be    = c_q.be;
    assign ram_wdata = c_q.wdata;

endmodule

// File: rtl/vfill_engine.sv
// Top: fill-mode DMA engine for a byte-addressed video memory.
module vfill_engine
    import vfill_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [REG_W-1:0]   reg_val,
    input  logic               cmd_wr,
    input  logic               cmd_dma,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               data_wr,
    input  logic [2*REG_W-1:0] data_val,
    output logic               ram_we,
    output logic [ADDR_W-2:0]  ram_addr,
    output logic [1:0]         ram_be,
    output logic [2*REG_W-1:0] ram_wdata,
    output logic               busy,
    output logic [2*REG_W-1:0] len_o,
    output logic [3*REG_W-1:0] src_o
);
    logic             fill_step;
    logic             fill_sel;
    logic [REG_W-1:0] inc;
    logic             reg_en;

    assign reg_en = reg_wr && !busy;

    vfill_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_en),
        .wr_idx     (reg_idx),
        .wr_val     (reg_val),
        .step       (fill_step),
        .inc_o      (inc),
        .len_o      (len_o),
        .src_o      (src_o),
        .fill_sel_o (fill_sel)
    );

    vfill_ctrl #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_dma   (cmd_dma),
        .cmd_addr  (cmd_addr),
        .data_wr   (data_wr),
        .data_val  (data_val),
        .fill_sel  (fill_sel),
        .len       (len_o),
        .inc       (inc),
        .fill_step (fill_step),
        .busy      (busy),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata)
    );

endmodule

// File: rtl/vfill_checker.sv
module vfill_checker #(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic               cmd_dma,
    input logic               data_wr,
    input logic               busy,
    input logic               ram_we,
    input logic [1:0]         ram_be,
    input logic [2*REG_W-1:0] len_o,
    input logic [3*REG_W-1:0] src_o,
    input logic               fill_step
);
    localparam int PAIR_W = 2 * REG_W;

    // R1: an accepted fill command raises busy
    p_arm_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_dma && src_o[3*REG_W-1] && !busy) |=> busy);

    // R2: without a fill command, idle stays idle
    p_stay_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_wr && cmd_dma && src_o[3*REG_W-1])) |=> !busy);

    // R4: no memory write while idle without a data word
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !data_wr) |=> !ram_we);

    // R5: each fill step yields one single-byte write
    p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_step |=> (ram_we && ($countones(ram_be) == 1)));

    // R6: length counts down per step
    p_len_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_step |=> (len_o == $past(len_o) - PAIR_W'(1)));

    // R7: source pointer counts up, high byte held
    p_src_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_step |=> ((src_o[PAIR_W-1:0] == $past(src_o[PAIR_W-1:0]) + PAIR_W'(1))
                       && (src_o[3*REG_W-1:PAIR_W] == $past(src_o[3*REG_W-1:PAIR_W]))));

    // R8: busy only drops with the length exhausted
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_o == '0));

    // R9: registers frozen while busy apart from fill steps
    p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_step) |=> ($stable(len_o) && $stable(src_o)));

endmodule

bind vfill_engine vfill_checker #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_dma   (cmd_dma),
    .data_wr   (data_wr),
    .busy      (busy),
    .ram_we    (ram_we),
    .ram_be    (ram_be),
    .len_o     (len_o),
    .src_o     (src_o),
    .fill_step (fill_step)
);

// File: tb/tb_vfill_engine.sv
module tb_vfill_engine;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [7:0]  reg_val = '0;
    logic        cmd_wr = 1'b0;
    logic        cmd_dma = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        data_wr = 1'b0;
    logic [15:0] data_val = '0;
    logic        ram_we;
    logic [14:0] ram_addr;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata;
    logic        busy;
    logic [15:0] len_o;
    logic [23:0] src_o;

    always #2.5 clk = ~clk;

    vfill_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_val(reg_val),
        .cmd_wr(cmd_wr), .cmd_dma(cmd_dma), .cmd_addr(cmd_addr),
        .data_wr(data_wr), .data_val(data_val),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be), .ram_wdata(ram_wdata),
        .busy(busy), .len_o(len_o), .src_o(src_o)
    );

    typedef struct packed {
        logic [14:0] wa;
        logic [1:0]  be;
        logic [15:0] wd;
        logic        last;
    } item_t;

    item_t      exp_q[$];
    string      tag_q[$];
    logic [7:0] vram [int];
    int         n_checks = 0;
    int         n_fail = 0;
    bit         idle_due = 1'b0;
    bit         finished = 1'b0;

    // bench-side model of the programmed registers
    logic [7:0]  b_inc = '0;
    logic [15:0] b_len = '0;
    logic [23:0] b_src = '0;
    logic [15:0] b_addr = '0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    function automatic logic [7:0] rd(input int a);
        return vram.exists(a) ? vram[a] : 8'h00;
    endfunction

    task automatic push_item(input logic [14:0] wa, input logic [1:0] be, input logic [15:0] wd,
                             input logic last, input string tag);
        item_t it;
        it.wa = wa; it.be = be; it.wd = wd; it.last = last;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // R3: even address keeps order, odd address swaps within the pair
    task automatic exp_word(input logic [15:0] a, input logic [15:0] w, input string tag);
        push_item(a[15:1], 2'b11, a[0] ? {w[7:0], w[15:8]} : w, 1'b0, tag);
    endtask

    task automatic exp_byte(input logic [15:0] a, input logic [7:0] b, input logic last, input string tag);
        push_item(a[15:1], a[0] ? 2'b01 : 2'b10, a[0] ? {8'h00, b} : {b, 8'h00}, last, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (idle_due) begin
            chk(busy == 1'b0, "R8 busy low after last fill byte", 32'(busy), 32'd0);
            idle_due = 1'b0;
        end
        if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected memory write", 32'(ram_addr), 32'd0);
            end else begin
                item_t e;
                string t;
                logic [15:0] mask;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                mask = {{8{e.be[1]}}, {8{e.be[0]}}};
                chk(ram_addr == e.wa, {t, " addr"}, 32'(ram_addr), 32'(e.wa));
                chk(ram_be == e.be, {t, " strobes"}, 32'(ram_be), 32'(e.be));
                chk((ram_wdata & mask) == (e.wd & mask), {t, " data"},
                    32'(ram_wdata & mask), 32'(e.wd & mask));
                if (e.last) begin
                    chk(busy == 1'b1, "R8 busy high on last fill byte", 32'(busy), 32'd1);
                    idle_due = 1'b1;
                end
            end
            if (ram_be[1]) vram[int'({ram_addr, 1'b0})] = ram_wdata[15:8];
            if (ram_be[0]) vram[int'({ram_addr, 1'b1})] = ram_wdata[7:0];
        end
    end

    task automatic raw_reg(input logic [4:0] idx, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_val = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic raw_cmd(input logic [15:0] a, input logic dma);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_addr = a; cmd_dma = dma;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_dma = 1'b0;
    endtask

    task automatic raw_data(input logic [15:0] w);
        @(negedge clk);
        data_wr = 1'b1; data_val = w;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // R1: register map used by the model
    task automatic set_reg(input logic [4:0] idx, input logic [7:0] val);
        case (idx)
            5'd15: b_inc = val;
            5'd19: b_len[7:0] = val;
            5'd20: b_len[15:8] = val;
            5'd21: b_src[7:0] = val;
            5'd22: b_src[15:8] = val;
            5'd23: b_src[23:16] = val;
            default: ;
        endcase
        raw_reg(idx, val);
    endtask

    task automatic send_cmd(input logic [15:0] a, input logic dma);
        b_addr = a;
        raw_cmd(a, dma);
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        exp_word(b_addr, w, tag);
        b_addr = b_addr + 16'(b_inc);
        raw_data(w);
    endtask

    task automatic arm_fill(input logic [15:0] a);
        send_cmd(a, 1'b1);
        chk(busy == 1'b1, "R1 busy after fill command", 32'(busy), 32'd1);
    endtask

    task automatic fire_fill(input logic [15:0] w, input string tag);
        int n;
        logic [15:0] a;
        n = (b_len == 16'd0) ? 65536 : int'(b_len);
        exp_word(b_addr, w, "R4 trigger word");
        a = b_addr + 16'(b_inc);
        for (int i = 0; i < n; i++) begin
            exp_byte(a ^ 16'h0001, w[15:8], (i == n - 1), tag);
            a = a + 16'(b_inc);
        end
        b_src[15:0] = b_src[15:0] + 16'(n);
        b_len = '0;
        b_addr = a;
        raw_data(w);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected writes seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic zero_area();
        set_reg(5'd15, 8'd2);
        send_cmd(16'h0100, 1'b0);
        for (int i = 0; i < 6; i++) send_word(16'h0000, "R3 clear word");
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] img_even [9];
        logic [7:0] img_odd [12];
        img_even = '{8'h11, 8'h22, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h11};
        img_odd  = '{8'h22, 8'h11, 8'h00, 8'h00, 8'h00, 8'h11, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
        chk(ram_we == 1'b0, "R4 reset no write", 32'(ram_we), 32'd0);
        chk(len_o == 16'd0, "R6 reset length", 32'(len_o), 32'd0);
        chk(src_o == 24'd0, "R7 reset source", 32'(src_o), 32'd0);

        // R3: plain words, even and odd addresses
        zero_area();
        send_cmd(16'h0301, 1'b0);
        send_word(16'hA1B2, "R3 odd word");
        repeat (2) @(negedge clk);
        chk(rd(16'h0300) == 8'hB2, "R3 odd word even byte", 32'(rd(16'h0300)), 32'hB2);
        chk(rd(16'h0301) == 8'hA1, "R3 odd word odd byte", 32'(rd(16'h0301)), 32'hA1);

        // R10 even example, with R7 source counting
        set_reg(5'd21, 8'h34);
        set_reg(5'd22, 8'h12);
        set_reg(5'd15, 8'd3);
        set_reg(5'd19, 8'd3);
        set_reg(5'd20, 8'd0);
        set_reg(5'd23, 8'h80);
        arm_fill(16'h0100);
        fire_fill(16'h1122, "R5 fill even");
        wait_idle();
        for (int i = 0; i < 9; i++)
            chk(rd(16'h0100 + i) == img_even[i], "R10 even image",
                32'(rd(16'h0100 + i)), 32'(img_even[i]));
        chk(len_o == 16'd0, "R6 length exhausted", 32'(len_o), 32'd0);
        chk(src_o == 24'h801237, "R7 source advanced", 32'(src_o), 32'h801237);

        // R7: reprogram only length and source-high
        set_reg(5'd19, 8'd2);
        set_reg(5'd23, 8'h05);
        chk(src_o == 24'h051237, "R7 source kept after reprogram", 32'(src_o), 32'h051237);

        // R2: copy-mode DMA command and plain command do not arm
        send_cmd(16'h0200, 1'b1);
        chk(busy == 1'b0, "R2 copy command no arm", 32'(busy), 32'd0);
        send_word(16'h7788, "R2 word after copy command");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2 still idle", 32'(busy), 32'd0);
        set_reg(5'd23, 8'h80);
        send_cmd(16'h0210, 1'b0);
        chk(busy == 1'b0, "R2 non-DMA command no arm", 32'(busy), 32'd0);
        send_word(16'h99AA, "R2 word after plain command");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 single word only", 32'(exp_q.size()), 32'd0);

        // R10 odd example
        zero_area();
        set_reg(5'd15, 8'd3);
        set_reg(5'd19, 8'd3);
        set_reg(5'd20, 8'd0);
        arm_fill(16'h0101);
        fire_fill(16'h1122, "R5 fill odd");
        wait_idle();
        for (int i = 0; i < 12; i++)
            chk(rd(16'h0100 + i) == img_odd[i], "R10 odd image",
                32'(rd(16'h0100 + i)), 32'(img_odd[i]));

        // R9: writes while armed and during a fill are ignored
        set_reg(5'd15, 8'd2);
        set_reg(5'd19, 8'd8);
        arm_fill(16'h0400);
        raw_reg(5'd15, 8'd9);
        raw_cmd(16'h0800, 1'b0);
        fire_fill(16'h3C5A, "R9 fill with interference");
        @(negedge clk);
        chk(len_o == 16'd7, "R6 length after first step", 32'(len_o), 32'd7);
        raw_data(16'hFFFF);
        raw_reg(5'd19, 8'h55);
        raw_cmd(16'h0900, 1'b1);
        wait_idle();
        chk(len_o == 16'd0, "R9 length write ignored", 32'(len_o), 32'd0);
        chk(src_o == b_src, "R7 source after fill", 32'(src_o), 32'(b_src));
        send_word(16'h1357, "R4 address continues after fill");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 continue word seen", 32'(exp_q.size()), 32'd0);

        // R6 zero length = 65536, R5 wrap
        set_reg(5'd15, 8'd1);
        set_reg(5'd19, 8'd0);
        set_reg(5'd20, 8'd0);
        arm_fill(16'hFFFE);
        fire_fill(16'h5A3C, "R6 zero-length fill");
        wait_idle();
        chk(len_o == 16'd0, "R6 zero-length end", 32'(len_o), 32'd0);
        chk(src_o == b_src, "R7 source wrap", 32'(src_o), 32'(b_src));
        chk(rd(16'h0001) == 8'h5A, "R5 address wrap", 32'(rd(16'h0001)), 32'h5A);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule